// File: doc/BRIEF.md
# Per-Source Configured Interrupt Controller

The controller collects 64 level-sensitive interrupt lines and turns them into a single request to the processor. Each line has its own 32-bit configuration word on a simple memory-mapped bus. The low seven bits of that word are a configuration field. A line counts as enabled only when the field holds the enable code of the selected variant. Software moves a line in or out of service by writing a new field value. The line's input and any pending state stay as they are.

The block has no edge latch. A line is pending for exactly as long as its input is high and its field holds the enable code. Every cycle the block picks the lowest-numbered pending line. It registers that number into a read-only identification word, and it registers the request line. Software reads the identification word to learn which line to service. The word returns an all-ones code when nothing is pending.

Top module: `sci_intc`

## Requirements
- R1: After reset every configuration word reads 0x00000000, `cpu_irq` is low, and the identification word reads 0x0000007F.
- R2: The configuration word of line n sits at byte address 4*n (n = 0..63). A full-word write there stores all 32 bits, and a later read returns them unchanged, including bits 31:7.
- R3: A line is enabled only when bits 6:0 of its word equal the enable code. That code is 0x51 when `VARIANT` is `VAR_A` (the default) and 0x20 when it is `VAR_B`. Every other field value, including 0x00, disables the line. Bits 31:7 have no effect on enabling.
- R4: Detection is by level, with no latch. When the input of an enabled line drops, its pending state is gone, even if the line was high for only one cycle.
- R5: `cpu_irq` is registered. It goes high on the clock edge after an enabled line is high at a clock edge. It goes low on the edge after no enabled line is high.
- R6: When several enabled lines are high, the identification word at byte address 0x100 reports the lowest line number in bits 6:0, and bits 31:7 read as zero. The value updates on the same edge as `cpu_irq`.
- R7: With no enabled line high, the identification word reads 0x7F in bits 6:0, and `cpu_irq` is low.
- R8: Disabling a high line removes it from the request and from the selection without clearing anything. Writing the enable code again while the input is still high restores the request on the following edge.
- R9: Writes to the identification word, to any other address with bit 8 set, or to an address whose bits 1:0 are not zero leave every configuration word and the identification word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 64 | Interrupt line levels, bit n is line n |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_we | input | 1 | Bus write (1) or read (0) |
| cpu_addr | input | 9 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational, zero when no read is selected |
| cpu_irq | output | 1 | Registered request to the processor |

## Verification
The bench targets single-cycle pulses. A design that latched them would keep `cpu_irq` high after the input falls. It probes the field with the other variant's code and with upper bits set over a zero field. A decoder that tested a single bit, or the whole word, would enable the line or refuse it wrongly. It disables the lowest of several active lines and then enables it again while the line stays high. A priority chain that ran the wrong way, or a mask that cleared state, would report the wrong number or never bring the request back. Writes to the identification word, to unmapped space and to misaligned addresses show whether the address decode folds those writes onto a configuration word.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int NUM_SRC = 64;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 7;

    typedef enum logic [0:0] {
        VAR_A = 1'b0,
        VAR_B = 1'b1
    } sci_variant_e;

    function automatic logic [FIELD_W-1:0] enable_code(sci_variant_e v);
        return (v == VAR_A) ? 7'h51 : 7'h20;
    endfunction

    typedef struct packed {
        logic                 wr;
        logic                 rd;
        logic                 cfg_hit;
        logic                 id_hit;
    } sci_decode_t;

endpackage

// File: rtl/sci_cfg_regs.sv
module sci_cfg_regs
    import sci_pkg::*;
#(
    parameter int           N       = 64,
    parameter sci_variant_e VARIANT = VAR_A,
    localparam int          IDX_W   = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [N-1:0]      src_en
);

    localparam logic [FIELD_W-1:0] EN_CODE = enable_code(VARIANT);

    logic [DATA_W-1:0] cfg_q [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cfg_q[g] <= wr_data;
            end
        end

        assign src_en[g] = (cfg_q[g][FIELD_W-1:0] == EN_CODE);
    end

    assign rd_data = cfg_q[rd_idx];

endmodule

// File: rtl/sci_prio_pick.sv
module sci_prio_pick #(
    parameter int  N     = 64,
    localparam int ID_W  = $clog2(N) + 1
) (
    input  logic [N-1:0]    pend,
    output logic            hit,
    output logic [ID_W-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit = 1'b1;
                idx = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/sci_out_stage.sv
module sci_out_stage #(
    parameter int  N    = 64,
    localparam int ID_W = $clog2(N) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    input  logic [ID_W-1:0] idx,
    output logic            irq_q,
    output logic [ID_W-1:0] id_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            id_q  <= '1;
        end else begin
            irq_q <= hit;
            id_q  <= hit ? idx : '1;
        end
    end

endmodule

// File: rtl/sci_intc.sv
module sci_intc
    import sci_pkg::*;
#(
    parameter int           N       = NUM_SRC,
    parameter sci_variant_e VARIANT = VAR_A,
    localparam int          IDX_W   = $clog2(N),
    localparam int          ID_W    = IDX_W + 1,
    localparam int          ADDR_W  = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      src_lvl,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_irq
);

    sci_decode_t        dec;
    logic [IDX_W-1:0]   word_idx;
    logic [DATA_W-1:0]  cfg_rd;
    logic [N-1:0]       src_en;
    logic [N-1:0]       pend;
    logic               pick_hit;
    logic [ID_W-1:0]    pick_idx;
    logic [ID_W-1:0]    pend_id_q;

    assign word_idx = cpu_addr[ADDR_W-2:2];

    always_comb begin
        dec.wr      = cpu_sel && cpu_we && (cpu_addr[1:0] == 2'b00);
        dec.rd      = cpu_sel && !cpu_we && (cpu_addr[1:0] == 2'b00);
        dec.cfg_hit = !cpu_addr[ADDR_W-1];
        dec.id_hit  = cpu_addr[ADDR_W-1] && (word_idx == '0);
    end

    sci_cfg_regs #(.N(N), .VARIANT(VARIANT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.wr && dec.cfg_hit),
        .wr_idx  (word_idx),
        .wr_data (cpu_wdata),
        .rd_idx  (word_idx),
        .rd_data (cfg_rd),
        .src_en  (src_en)
    );

    assign pend = src_lvl & src_en;

    sci_prio_pick #(.N(N)) u_pick (
        .pend (pend),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    sci_out_stage #(.N(N)) u_out (
        .clk   (clk),
        .rst   (rst),
        .hit   (pick_hit),
        .idx   (pick_idx),
        .irq_q (cpu_irq),
        .id_q  (pend_id_q)
    );

    always_comb begin
        cpu_rdata = '0;
        if (dec.rd) begin
            if (dec.cfg_hit) begin
                cpu_rdata = cfg_rd;
            end else if (dec.id_hit) begin
                cpu_rdata = {{(DATA_W-ID_W){1'b0}}, pend_id_q};
            end
        end
    end

endmodule

// File: rtl/sci_intc_chk.sv
module sci_intc_chk #(
    parameter int  N     = 64,
    localparam int IDX_W = $clog2(N),
    localparam int ID_W  = IDX_W + 1
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    src_lvl,
    input logic [N-1:0]    src_en,
    input logic            irq_o,
    input logic [ID_W-1:0] id_q
);

    logic [N-1:0] lvl_d;
    logic [N-1:0] en_d;
    logic [N-1:0] below_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= '0;
            en_d  <= '0;
        end else begin
            lvl_d <= src_lvl;
            en_d  <= src_en;
        end
    end

    always_comb begin
        below_m = ({{(N-1){1'b0}}, 1'b1} << id_q[IDX_W-1:0]) - {{(N-1){1'b0}}, 1'b1};
    end

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (|(src_lvl & src_en)) |=> irq_o);

    p_irq_fall_r4: assert property (@(posedge clk) disable iff (rst)
        !(|(src_lvl & src_en)) |=> !irq_o);

    p_none_code_r7: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (id_q == '1));

    p_winner_valid_r3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (en_d[id_q[IDX_W-1:0]] && lvl_d[id_q[IDX_W-1:0]] && !id_q[ID_W-1]));

    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((lvl_d & en_d & below_m) == '0));

endmodule

bind sci_intc sci_intc_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_lvl (src_lvl),
    .src_en  (src_en),
    .irq_o   (cpu_irq),
    .id_q    (pend_id_q)
);

// File: tb/sci_intc_tb.sv
module sci_intc_tb_top;

    localparam logic [6:0] EN = 7'h51;
    localparam logic [6:0] OTHER_EN = 7'h20;
    localparam logic [31:0] ID_ADDR = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] lvl = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit [31:0] mdl [64];

    always #4 clk = ~clk;

    sci_intc dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_lvl   (lvl),
        .cpu_sel   (sel),
        .cpu_we    (we),
        .cpu_addr  (addr),
        .cpu_wdata (wdata),
        .cpu_rdata (rdata),
        .cpu_irq   (irq)
    );

    function automatic logic [31:0] exp_id(logic [63:0] l);
        for (int i = 0; i < 64; i++) begin
            if (l[i] && (mdl[i][6:0] == EN)) return 32'(i);
        end
        return 32'h7F;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        if (a[8] == 1'b0 && a[1:0] == 2'b00) mdl[a[7:2]] = d;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    // set levels at a falling edge, let one rising edge pass, land on the next falling edge
    task automatic drive_and_settle(logic [63:0] l);
        @(negedge clk);
        lvl = l;
        @(negedge clk);
    endtask

    task automatic check_out(string req);
        logic [31:0] v;
        check(req, 32'(irq), 32'(exp_id(lvl) != 32'h7F));
        rd(9'h100, v);
        check(req, v, exp_id(lvl));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] snap0, snap5;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        rd(9'h000, v); check("R1 cfg0", v, 32'd0);
        rd(9'h0FC, v); check("R1 cfg63", v, 32'd0);
        rd(9'h100, v); check("R1 id", v, 32'h7F);

        // R2 offsets and full-word storage
        wr(9'h000, 32'hDEAD_BE80);
        wr(9'h0FC, 32'h1234_5600);
        wr(9'h014, 32'hFFFF_FF80);
        rd(9'h000, v); check("R2 cfg0", v, 32'hDEAD_BE80);
        rd(9'h0FC, v); check("R2 cfg63", v, 32'h1234_5600);
        rd(9'h014, v); check("R2 cfg5", v, 32'hFFFF_FF80);

        // R3 upper bits with zero field: disabled
        drive_and_settle(64'h21);
        check("R3 upper-bits-only", 32'(irq), 32'd0);
        // R3 other variant code: disabled
        wr(9'h014, {25'h0, OTHER_EN});
        drive_and_settle(64'h20);
        check("R3 other-code", 32'(irq), 32'd0);
        // R3 enable code with upper bits set
        wr(9'h014, {25'h1AB_CDEF, EN});
        @(negedge clk);
        check("R3 enabled irq", 32'(irq), 32'd1);
        rd(9'h100, v); check("R3 enabled id", v, 32'd5);

        // R5 registered timing: one edge of delay each way
        wr(9'h00C, {25'h0, EN});
        @(negedge clk); lvl = 64'h0;
        #1 check("R5 hold before edge", 32'(irq), 32'd1);
        @(negedge clk);
        check("R5 fall after edge", 32'(irq), 32'd0);
        lvl = 64'h8;
        #1 check("R5 no rise before edge", 32'(irq), 32'd0);
        @(negedge clk);
        check("R5 rise after edge", 32'(irq), 32'd1);
        rd(9'h100, v); check("R5 id", v, 32'd3);

        // R4 single-cycle pulse, no latch
        lvl = 64'h0;
        @(negedge clk);
        lvl = 64'h20;
        @(negedge clk);
        lvl = 64'h0;
        check("R4 pulse seen", 32'(irq), 32'd1);
        @(negedge clk);
        check("R4 pulse not latched", 32'(irq), 32'd0);
        rd(9'h100, v); check("R7 none after pulse", v, 32'h7F);

        // R6 lowest wins among 3,5,63
        wr(9'h0FC, {25'h0, EN});
        drive_and_settle(64'h8000_0000_0000_0028);
        rd(9'h100, v); check("R6 lowest of 3,5,63", v, 32'd3);

        // R8 disable lowest while high, then restore
        wr(9'h00C, 32'h0);
        @(negedge clk);
        rd(9'h100, v); check("R8 masked moves to 5", v, 32'd5);
        wr(9'h014, 32'h0);
        @(negedge clk);
        rd(9'h100, v); check("R8 masked moves to 63", v, 32'd63);
        wr(9'h00C, {25'h0, EN});
        @(negedge clk);
        rd(9'h100, v); check("R8 restored 3", v, 32'd3);
        check("R8 irq", 32'(irq), 32'd1);

        // R9 writes to id, unmapped, misaligned are ignored
        rd(9'h000, snap0); rd(9'h014, snap5);
        wr(9'h100, {25'h0, EN});
        wr(9'h114, 32'h0);
        wr(9'h1FC, 32'hFFFF_FFFF);
        wr(9'h00D, 32'h0);
        wr(9'h016, {25'h0, EN});
        @(negedge clk);
        rd(9'h000, v); check("R9 cfg0 kept", v, snap0);
        rd(9'h014, v); check("R9 cfg5 kept", v, snap5);
        rd(9'h00C, v); check("R9 cfg3 kept", v, {25'h0, EN});
        rd(9'h100, v); check("R9 id kept", v, 32'd3);

        // R7 nothing pending
        drive_and_settle(64'h0);
        check_out("R7 idle");

        // random phase, R3 R6 R7
        for (int it = 0; it < 300; it++) begin
            int nw;
            nw = $urandom_range(0, 3);
            for (int k = 0; k < nw; k++) begin
                logic [5:0] s;
                logic [6:0] f;
                int pick;
                s = 6'($urandom_range(0, 63));
                pick = $urandom_range(0, 3);
                f = (pick == 0) ? 7'h00 : (pick == 1) ? OTHER_EN :
                    (pick == 2) ? EN : 7'($urandom);
                wr({1'b0, s, 2'b00}, {25'($urandom), f});
            end
            drive_and_settle({$urandom, $urandom} & {$urandom, $urandom});
            check_out("R6 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule